// File: doc/BRIEF.md
# Branch Next-PC Resolver

This unit chooses the program counter for the following instruction once a branch has been decoded. Each cycle it takes the current PC and the decoded branch fields. These are the branch kind, a 26-bit word offset, a 19-bit word offset, a register operand and a 4-bit condition code, together with the N, Z, C and V flags. It produces the next PC, a taken flag and a flag for an unsupported condition code. It does not fetch, decode or generate flags.

The unit has three kinds of branch. A relative jump always moves by its 26-bit offset. An indirect jump copies the register operand into the PC. A guarded jump moves by its 19-bit offset only when the condition code holds against the flags, and otherwise steps to the next sequential instruction. Every result is registered once, so each output is valid on the clock edge that follows the cycle in which its inputs were applied.

There is no state machine. The only sequential element is the output register, which has two conditions: in reset, or loading the resolved result on every edge.

Top module: `npc_unit`

## Requirements
- R1: While rst_n is low, next_pc_o, taken_o and cond_err_o are all zero.
- R2: When kind_i is 00 (relative jump), next_pc_o equals pc_i plus four times the sign-extended off26_i. In the same result taken_o is 1 and cond_err_o is 0.
- R3: When kind_i is 01 (indirect jump), next_pc_o equals reg_val_i, taken_o is 1 and cond_err_o is 0.
- R4: When kind_i is 10 (guarded jump) and the condition holds, next_pc_o equals pc_i plus four times the sign-extended off19_i, and taken_o is 1.
- R5: When kind_i is 10 and the condition fails, next_pc_o equals pc_i + 4 and taken_o is 0. Whenever taken_o is 0, next_pc_o is pc_i + 4.
- R6: Code 0000 holds when Z=1. Code 0001 holds when Z=0.
- R7: Code 1010 holds when N equals V. Code 1011 holds when N differs from V.
- R8: Code 1100 holds when Z=0 and N equals V. Code 1101 holds when Z=1 or N differs from V.
- R9: Code 1110 holds for every flag combination.
- R10: Any other code with kind_i=10 sets cond_err_o to 1, clears taken_o and gives pc_i + 4. For any other kind, cond_err_o stays 0.
- R11: kind_i 11 is reserved. It gives pc_i + 4 with taken_o=0 and cond_err_o=0.
- R12: The C flag has no effect on any output.
- R13: Results appear one clock edge after their inputs. All sums wrap modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | PC_W | Current program counter |
| kind_i | input | 2 | Branch kind: 00 relative, 01 indirect, 10 guarded, 11 reserved |
| off26_i | input | IMM_W | Word offset for a relative jump |
| off19_i | input | CND_W | Word offset for a guarded jump |
| reg_val_i | input | PC_W | Register operand for an indirect jump |
| cond_i | input | 4 | Condition code |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag (ignored) |
| flag_v_i | input | 1 | Overflow flag |
| next_pc_o | output | PC_W | Resolved next PC |
| taken_o | output | 1 | Branch taken |
| cond_err_o | output | 1 | Unsupported condition code on a guarded jump |

## Verification
All three outputs are due exactly one rising edge after their inputs are applied. The bench changes inputs 1 ns after an edge, waits for the next rising edge and samples 1 ns later, so every check lands in the cycle where its result first appears. The guarded-jump sweep covers all 16 codes against all 16 flag combinations. An independent arithmetic model gives the expected value for each of those checks.

// File: rtl/npc_pkg.sv
package npc_pkg;
    typedef enum logic [1:0] {
        BR_REL  = 2'b00,
        BR_IND  = 2'b01,
        BR_GRD  = 2'b10,
        BR_RSVD = 2'b11
    } br_kind_e;

    typedef enum logic [3:0] {
        CC_EQ = 4'b0000,
        CC_NE = 4'b0001,
        CC_GE = 4'b1010,
        CC_LT = 4'b1011,
        CC_GT = 4'b1100,
        CC_LE = 4'b1101,
        CC_AL = 4'b1110
    } cc_e;

    localparam int INSN_BYTES = 4;
    localparam int WORD_SHIFT = 2;
endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
    import npc_pkg::*;
(
    input  logic [3:0] cond_i,
    input  logic       n_i,
    input  logic       z_i,
    input  logic       v_i,
    output logic       hold_o,
    output logic       bad_o
);
    logic sign_ok;
    assign sign_ok = (n_i == v_i);

    // R6 R7 R8 R9 R10: condition decode
    always_comb begin
        hold_o = 1'b0;
        bad_o  = 1'b0;
        unique case (cond_i)
            CC_EQ:   hold_o = z_i;
            CC_NE:   hold_o = !z_i;
            CC_GE:   hold_o = sign_ok;
            CC_LT:   hold_o = !sign_ok;
            CC_GT:   hold_o = !z_i && sign_ok;
            CC_LE:   hold_o = z_i || !sign_ok;
            CC_AL:   hold_o = 1'b1;
            default: bad_o  = 1'b1;
        endcase
    end
endmodule

// File: rtl/npc_off_add.sv
module npc_off_add
    import npc_pkg::*;
#(
    parameter int PC_W  = 64,
    parameter int OFF_W = 26
) (
    input  logic [PC_W-1:0]  base_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PC_W-1:0]  sum_o
);
    localparam int EXT_W = PC_W - OFF_W - WORD_SHIFT;

    logic [PC_W-1:0] byte_off;
    assign byte_off = {{EXT_W{off_i[OFF_W-1]}}, off_i, {WORD_SHIFT{1'b0}}};
    assign sum_o    = base_i + byte_off;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int PC_W  = 64,
    parameter int IMM_W = 26,
    parameter int CND_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [1:0]       kind_i,
    input  logic [IMM_W-1:0] off26_i,
    input  logic [CND_W-1:0] off19_i,
    input  logic [PC_W-1:0]  reg_val_i,
    input  logic [3:0]       cond_i,
    input  logic             flag_n_i,
    input  logic             flag_z_i,
    input  logic             flag_c_i,
    input  logic             flag_v_i,
    output logic [PC_W-1:0]  next_pc_o,
    output logic             taken_o,
    output logic             cond_err_o
);
    logic [PC_W-1:0] seq_pc, rel_pc, grd_pc;
    logic            cc_hold, cc_bad;
    logic [PC_W-1:0] nxt_pc;
    logic            nxt_taken, nxt_err;
    logic            unused_carry;

    // R12: carry takes part in no condition
    assign unused_carry = flag_c_i;
    assign seq_pc       = pc_i + PC_W'(INSN_BYTES);

    npc_off_add #(.PC_W(PC_W), .OFF_W(IMM_W)) u_rel (
        .base_i(pc_i), .off_i(off26_i), .sum_o(rel_pc)
    );

    npc_off_add #(.PC_W(PC_W), .OFF_W(CND_W)) u_grd (
        .base_i(pc_i), .off_i(off19_i), .sum_o(grd_pc)
    );

    npc_cond_eval u_cc (
        .cond_i(cond_i), .n_i(flag_n_i), .z_i(flag_z_i), .v_i(flag_v_i),
        .hold_o(cc_hold), .bad_o(cc_bad)
    );

    // R2 R3 R4 R5 R10 R11: selection
    always_comb begin
        nxt_pc    = seq_pc;
        nxt_taken = 1'b0;
        nxt_err   = 1'b0;
        unique case (br_kind_e'(kind_i))
            BR_REL: begin
                nxt_pc    = rel_pc;
                nxt_taken = 1'b1;
            end
            BR_IND: begin
                nxt_pc    = reg_val_i;
                nxt_taken = 1'b1;
            end
            BR_GRD: begin
                if (cc_bad) begin
                    nxt_err = 1'b1;
                end else if (cc_hold) begin
                    nxt_pc    = grd_pc;
                    nxt_taken = 1'b1;
                end
            end
            BR_RSVD: begin
                nxt_pc = seq_pc;
            end
        endcase
    end

    // R1 R13: output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc_o  <= '0;
            taken_o    <= 1'b0;
            cond_err_o <= 1'b0;
        end else begin
            next_pc_o  <= nxt_pc;
            taken_o    <= nxt_taken;
            cond_err_o <= nxt_err;
        end
    end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int PC_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] pc_i,
    input logic [1:0]      kind_i,
    input logic [PC_W-1:0] reg_val_i,
    input logic [3:0]      cond_i,
    input logic [PC_W-1:0] next_pc_o,
    input logic            taken_o,
    input logic            cond_err_o
);
    a_r2_rel_taken: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(kind_i) == 2'b00) |-> (taken_o && !cond_err_o));

    a_r3_ind_target: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(kind_i) == 2'b01) |-> (taken_o && next_pc_o == $past(reg_val_i)));

    a_r5_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !taken_o) |-> (next_pc_o == $past(pc_i) + PC_W'(4)));

    a_r9_always: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(kind_i) == 2'b10 && $past(cond_i) == 4'b1110) |-> taken_o);

    a_r10_err_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
        cond_err_o |-> !taken_o);

    a_r10_err_only_grd: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(kind_i) != 2'b10) |-> !cond_err_o);

    a_r11_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(kind_i) == 2'b11) |-> (!taken_o && !cond_err_o));
endmodule

bind npc_unit npc_unit_chk #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .kind_i(kind_i),
    .reg_val_i(reg_val_i), .cond_i(cond_i), .next_pc_o(next_pc_o),
    .taken_o(taken_o), .cond_err_o(cond_err_o)
);

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] pc_i, reg_val_i, next_pc_o;
    logic [1:0]  kind_i;
    logic [25:0] off26_i;
    logic [18:0] off19_i;
    logic [3:0]  cond_i;
    logic        flag_n_i, flag_z_i, flag_c_i, flag_v_i;
    logic        taken_o, cond_err_o;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    npc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .kind_i(kind_i),
        .off26_i(off26_i), .off19_i(off19_i), .reg_val_i(reg_val_i),
        .cond_i(cond_i), .flag_n_i(flag_n_i), .flag_z_i(flag_z_i),
        .flag_c_i(flag_c_i), .flag_v_i(flag_v_i), .next_pc_o(next_pc_o),
        .taken_o(taken_o), .cond_err_o(cond_err_o)
    );

    function automatic logic [63:0] rel_target(logic [63:0] pc, longint off, int bits);
        longint s;
        s = (off >= (longint'(1) << (bits - 1))) ? off - (longint'(1) << bits) : off;
        return pc + 64'(s * 4);
    endfunction

    task automatic check(string tag, logic [63:0] ep, logic et, logic ee);
        checks++;
        if (next_pc_o !== ep || taken_o !== et || cond_err_o !== ee) begin
            failures++;
            $display("FAIL %s: got pc=%h taken=%b err=%b, expected pc=%h taken=%b err=%b",
                     tag, next_pc_o, taken_o, cond_err_o, ep, et, ee);
        end
    endtask

    task automatic apply(logic [1:0] k, logic [63:0] pc, logic [25:0] o26, logic [18:0] o19,
                         logic [63:0] rv, logic [3:0] cc, logic [3:0] f);
        kind_i = k; pc_i = pc; off26_i = o26; off19_i = o19; reg_val_i = rv; cond_i = cc;
        {flag_n_i, flag_z_i, flag_c_i, flag_v_i} = f;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        kind_i = 2'b00; pc_i = 64'h1234; off26_i = 26'h5; off19_i = '0;
        reg_val_i = '1; cond_i = '0;
        {flag_n_i, flag_z_i, flag_c_i, flag_v_i} = 4'h0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 64'h0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R2 relative jump, R13 wrap
        apply(2'b00, 64'h1000, 26'h10, 19'h0, 64'h0, 4'hF, 4'h0);
        check("R2 positive", 64'h1040, 1'b1, 1'b0);
        apply(2'b00, 64'h1000, 26'h3FFFFFF, 19'h0, 64'h0, 4'h0, 4'h0);
        check("R2 minus one word", 64'h0FFC, 1'b1, 1'b0);
        apply(2'b00, 64'h8000_0000, 26'h2000000, 19'h0, 64'h0, 4'h0, 4'h0);
        check("R2 most negative", rel_target(64'h8000_0000, 64'h2000000, 26), 1'b1, 1'b0);
        apply(2'b00, 64'h4, 26'h3FFFFFE, 19'h0, 64'h0, 4'h0, 4'h0);
        check("R13 wrap below zero", 64'hFFFF_FFFF_FFFF_FFFC, 1'b1, 1'b0);

        // R3 indirect
        apply(2'b01, 64'h2000, 26'h1, 19'h1, 64'hDEAD_BEEF_0000_0010, 4'h3, 4'h5);
        check("R3 indirect", 64'hDEAD_BEEF_0000_0010, 1'b1, 1'b0);
        apply(2'b01, 64'h2000, 26'h0, 19'h0, 64'h0, 4'h0, 4'h0);
        check("R3 indirect zero", 64'h0, 1'b1, 1'b0);

        // R11 reserved kind
        apply(2'b11, 64'h3000, 26'h44, 19'h44, 64'h9, 4'hF, 4'hF);
        check("R11 reserved", 64'h3004, 1'b0, 1'b0);
        apply(2'b11, 64'hFFFF_FFFF_FFFF_FFFC, 26'h0, 19'h0, 64'h0, 4'hE, 4'h0);
        check("R13 seq wrap", 64'h0, 1'b0, 1'b0);

        // R4 R5 R6..R10: full code x flag sweep
        for (int cc = 0; cc < 16; cc++) begin
            for (int f = 0; f < 16; f++) begin
                logic n, z, v, hold, bad;
                logic [63:0] pc;
                logic [18:0] o19;
                string tag;
                n = f[3]; z = f[2]; v = f[0];
                bad = 1'b0; hold = 1'b0;
                case (cc)
                    0:  begin hold = z;                 tag = "R6 EQ"; end
                    1:  begin hold = !z;                tag = "R6 NE"; end
                    10: begin hold = (n == v);          tag = "R7 GE"; end
                    11: begin hold = (n != v);          tag = "R7 LT"; end
                    12: begin hold = !z && (n == v);    tag = "R8 GT"; end
                    13: begin hold = z || (n != v);     tag = "R8 LE"; end
                    14: begin hold = 1'b1;              tag = "R9 AL"; end
                    default: begin bad = 1'b1;          tag = "R10 bad code"; end
                endcase
                if (f[1]) tag = {tag, " R12 carry set"};
                pc  = 64'h10_0000 + 64'(cc * 256 + f * 16);
                o19 = (f[0]) ? 19'h7FFF0 : 19'(cc * 3 + f + 1);
                apply(2'b10, pc, 26'h155, o19, 64'hABC, 4'(cc), 4'(f));
                if (hold && !bad)
                    check({tag, " R4 taken"}, rel_target(pc, 64'(o19), 19), 1'b1, 1'b0);
                else
                    check({tag, " R5 not taken"}, pc + 64'd4, 1'b0, bad);
            end
        end

        // R4 extreme offsets
        apply(2'b10, 64'h100000, 26'h0, 19'h3FFFF, 64'h0, 4'hE, 4'h0);
        check("R4 max forward", 64'h100000 + 64'h3FFFF * 4, 1'b1, 1'b0);
        apply(2'b10, 64'h100000, 26'h0, 19'h40000, 64'h0, 4'hE, 4'h0);
        check("R4 max backward", 64'h100000 - 64'h40000 * 4, 1'b1, 1'b0);

        // R12 carry alone changes nothing
        apply(2'b10, 64'h500, 26'h0, 19'h8, 64'h0, 4'h0, 4'b0010);
        check("R12 carry only EQ", 64'h504, 1'b0, 1'b0);

        // R1 reset again clears outputs
        rst_n = 1'b0;
        apply(2'b01, 64'h0, 26'h0, 19'h0, 64'hFFFF, 4'h0, 4'h0);
        check("R1 reset mid-run", 64'h0, 1'b0, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule